// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside an I2C controller core and turns the core's single-cycle event pulses into sticky pending flags. Seven event kinds are tracked: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop detected and addressed as slave. A mask register chooses which pending flags may raise the interrupt line. A vector register reports the most urgent enabled pending event as a small code.

Software services the line by reading the vector register over and over until it returns zero. Each read that returns a nonzero code also retires that event. Some flags are also visible in a status word, where access ready and stop detected can be cleared by writing ones. The status word also shows the live bus-busy and receive-shift-full levels from the core.

Register reads are combinational from the current state. Clears caused by a read or a write take effect at the clock edge that ends the access.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset no event is pending, the mask register reads 0, the vector register reads 0 and `irq` is low.
- R2: The mask register at offset 0x04 holds bits 6:0 as written. Bit i enables the event whose vector code is i+1. Bits 15:7 read 0.
- R3: A pulse on any event input sets that event's pending flag at the next clock edge, whether or not it is masked. The status word at offset 0x08 shows pending arbitration lost at bit 0, no-acknowledge at bit 1, access ready at bit 2 and stop detected at bit 5.
- R4: `irq` is high exactly when at least one pending event is enabled in the mask register.
- R5: The vector register at offset 0x28 returns code 1 for arbitration lost, 2 for no-acknowledge, 3 for access ready, 4 for receive ready, 5 for transmit ready, 6 for stop detected and 7 for addressed as slave. It returns 0 when no enabled event is pending.
- R6: When several enabled events are pending, the vector register returns the lowest code among them.
- R7: A read of the vector register clears only the event whose code it returns. A read that returns 0 clears nothing.
- R8: Writing 1 to status bit 2 or bit 5 clears access ready or stop detected. Writing 0 leaves them set. A status write never clears arbitration lost or no-acknowledge.
- R9: Status bit 12 follows the `bus_busy` input and bit 11 follows the `rx_shift_full` input, live. Reads and writes do not change them.
- R10: An event pulse in the same cycle as a vector read or status write that would clear that event leaves the event pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_acc_rdy | input | 1 | Access ready pulse |
| ev_rx_rdy | input | 1 | Receive data ready pulse |
| ev_tx_rdy | input | 1 | Transmit ready pulse |
| ev_stop | input | 1 | Stop detected pulse |
| ev_addr_slave | input | 1 | Addressed-as-slave pulse |
| bus_busy | input | 1 | Bus busy level |
| rx_shift_full | input | 1 | Receive shift register full level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: an 8-bit offset and registers at 0x04, 0x08 and 0x28. This places every documented register at its real offset. It makes the full seven-code priority chain reachable in a drain loop of vector reads. It also allows event pulses to be placed in the same cycle as a clearing read or write, so the collision rule can be checked.

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] VEC_OFS  = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_arb_lost,
  input  logic              ev_nack,
  input  logic              ev_acc_rdy,
  input  logic              ev_rx_rdy,
  input  logic              ev_tx_rdy,
  input  logic              ev_stop,
  input  logic              ev_addr_slave,
  input  logic              bus_busy,
  input  logic              rx_shift_full,
  output logic              irq
);
  localparam int NEV    = 7;
  localparam int CODE_W = $clog2(NEV + 1);

  logic [NEV-1:0]    ev, pend, mask, act, sel, clr;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] status;
  logic              vec_rd, stat_wr;

  assign ev      = {ev_addr_slave, ev_stop, ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack, ev_arb_lost};
  assign act     = pend & mask;
  assign irq     = |act;
  assign vec_rd  = reg_rd && reg_addr == VEC_OFS;
  assign stat_wr = reg_wr && reg_addr == STAT_OFS;

  always_comb begin
    code = '0;
    sel  = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (act[i]) begin
        code = CODE_W'(i + 1);
        sel  = NEV'(1) << i;
      end
    end
  end

  always_comb begin
    clr = vec_rd ? sel : '0;
    if (stat_wr) begin
      clr[2] = clr[2] | reg_wdata[2];
      clr[5] = clr[5] | reg_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= (pend & ~clr) | ev;
      if (reg_wr && reg_addr == MASK_OFS) mask <= reg_wdata[NEV-1:0];
    end
  end

  always_comb begin
    status     = '0;
    status[0]  = pend[0];
    status[1]  = pend[1];
    status[2]  = pend[2];
    status[5]  = pend[5];
    status[11] = rx_shift_full;
    status[12] = bus_busy;
  end

  always_comb begin
    case (reg_addr)
      MASK_OFS: reg_rdata = DATA_W'(mask);
      STAT_OFS: reg_rdata = status;
      VEC_OFS:  reg_rdata = DATA_W'(code);
      default:  reg_rdata = '0;
    endcase
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (pend == '0 && !irq)); // R1
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((pend & $past(ev)) == $past(ev))); // R10
  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n) irq == (code != '0)); // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel)); // R6
  AST_VEC_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && sel != '0 && (sel & ev) == '0) |=> ((pend & $past(sel)) == '0)); // R7
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !reg_wdata[2] && pend[2] && !vec_rd) |=> pend[2]); // R8
endmodule

// File: tb/i2c_irq_vector_test.sv
module i2c_irq_vector_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [6:0] ev = 0;
  logic bus_busy = 0, rx_shift_full = 0, irq;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28;

  always #10 clk = ~clk;

  i2c_irq_vector uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]), .ev_rx_rdy(ev[3]),
    .ev_tx_rdy(ev[4]), .ev_stop(ev[5]), .ev_addr_slave(ev[6]),
    .bus_busy(bus_busy), .rx_shift_full(rx_shift_full), .irq(irq));

  always @(negedge clk) begin
    if (reg_rd && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s: read 0x%02h got 0x%04h expected 0x%04h", t, reg_addr, reg_rdata, e);
      end
    end
  end

  task automatic cyc(input bit rd, input bit wr, input logic [7:0] a, input logic [15:0] wd,
                     input logic [6:0] e, input logic [15:0] expv, input string t);
    @(posedge clk); #1;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; ev = e;
    if (rd) begin exp_q.push_back(expv); tag_q.push_back(t); end
    @(posedge clk); #1;
    reg_rd = 0; reg_wr = 0; ev = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] expv, input string t);
    cyc(1, 0, a, 0, 0, expv, t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cyc(0, 1, a, d, 0, 0, "");
  endtask

  task automatic pulse(input logic [6:0] e);
    cyc(0, 0, 0, 0, e, 0, "");
  endtask

  task automatic chk_irq(input bit expv, input string t);
    @(negedge clk);
    tests++;
    if (irq !== expv) begin
      fails++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq, expv);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(A_VEC, 16'h0000, "R1 vector");
    rd(A_MASK, 16'h0000, "R1 mask");
    rd(A_STAT, 16'h0000, "R1 status");
    chk_irq(0, "R1 irq");

    bus_busy = 1; rx_shift_full = 1;
    rd(A_STAT, 16'h1800, "R9 live levels");

    pulse(7'b0000010);
    rd(A_STAT, 16'h1802, "R3 masked nack visible");
    chk_irq(0, "R4 masked event no irq");
    rd(A_VEC, 16'h0000, "R5 masked gives zero");

    wr(A_MASK, 16'hFFFF);
    rd(A_MASK, 16'h007F, "R2 mask width");
    chk_irq(1, "R4 enabled irq");

    pulse(7'b0110001);
    rd(A_VEC, 16'd1, "R6 arb first");
    rd(A_VEC, 16'd2, "R6 nack next");
    rd(A_VEC, 16'd5, "R7 tx after");
    rd(A_VEC, 16'd6, "R7 stop last");
    rd(A_VEC, 16'd0, "R7 drained");
    chk_irq(0, "R4 drained irq");
    rd(A_STAT, 16'h1800, "R9 levels kept");

    pulse(7'b0100100);
    rd(A_STAT, 16'h1824, "R3 ardy and stop bits");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h1824, "R8 write zero keeps");
    wr(A_STAT, 16'h0004);
    rd(A_STAT, 16'h1820, "R8 clear ardy");
    pulse(7'b0000001);
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, 16'h1801, "R8 arb not write-clearable");
    rd(A_VEC, 16'd1, "R5 arb code");
    rd(A_VEC, 16'd0, "R7 arb retired");

    pulse(7'b0001000);
    cyc(1, 0, A_VEC, 0, 7'b0001000, 16'd4, "R10 rx read collision");
    rd(A_VEC, 16'd4, "R10 rx still pending");
    rd(A_VEC, 16'd0, "R7 rx retired");
    pulse(7'b0000100);
    cyc(0, 1, A_STAT, 16'h0004, 7'b0000100, 0, "");
    rd(A_STAT, 16'h1804, "R10 ardy write collision");
    rd(A_VEC, 16'd3, "R5 ardy code");

    wr(A_MASK, 16'h0040);
    pulse(7'b1000001);
    rd(A_VEC, 16'd7, "R5 aas code with arb masked");
    chk_irq(0, "R4 after aas retired");
    rd(A_STAT, 16'h1801, "R3 masked arb kept");
    bus_busy = 0;
    rd(A_STAT, 16'h0801, "R9 busy follows input");

    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule